// File: doc/BRIEF.md
# Paired-Beat CRC-32 Engine

This block computes the CRC-32 of byte packets that arrive as a stream of 32-bit beats on four byte lanes. Each beat carries four data bytes and a per-lane valid bit. A front-end stage pairs two consecutive beats into one 64-bit word and issues a one-cycle update enable. The CRC register therefore folds in eight bytes on every second beat, and each update has a full cycle to settle.

The final word of a packet may hold any count from one to eight bytes. A bank of parallel update networks, one for each byte count, works on that word, and the count taken from the lane valid bits selects one result. A packet that ends on the first beat of a pair is sent to the update stage at once, with its upper half marked empty. The complemented result appears with a one-cycle done strobe. The state presets itself for the next packet, which may start on the very next beat.

Top module: `crc64_pair_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done_o` is 0 and `crc_o` is zero.
- R2: The checksum is the reflected CRC-32: polynomial 0xEDB88320 processed LSB first, register preset to all ones, and the result complemented. The nine ASCII bytes "123456789" give 0xCBF43926.
- R3: Byte order follows lanes and then beats. Beat j of a packet carries message bytes 4j to 4j+3. Lane i, on `in_data[8i+7:8i]`, holds byte 4j+i.
- R4: `in_keep` marks valid lanes as a contiguous run starting at lane 0. It is 4'b1111 on every beat except the last, and the last beat has 1 to 4 bits set. Data in lanes whose keep bit is 0 has no effect on the result.
- R5: For every packet length from 1 to 70 bytes, `crc_o` equals the R2 checksum of the packet. This covers final 64-bit words of 1 to 8 bytes, including packets that end on the first beat of a pair.
- R6: A cycle with `in_valid` low is ignored, whatever `in_data`, `in_keep` and `in_last` hold, and such gaps may fall anywhere inside or between packets.
- R7: `done_o` is high for exactly one cycle per packet, two clock edges after the edge that accepts the final beat, whether the packet ends on the first or the second beat of a pair. `crc_o` changes only when `done_o` rises and holds its value until the next done.
- R8: The first beat of a new packet may follow the final beat of the previous packet with no idle cycle, and each packet starts from the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A beat is present on this cycle |
| in_data | input | 32 | Four byte lanes, lane 0 in bits 7:0 |
| in_keep | input | 4 | Per-lane byte valid bits |
| in_last | input | 1 | This beat ends the packet |
| done_o | output | 1 | One-cycle strobe when a packet's checksum is ready |
| crc_o | output | 32 | Checksum of the most recently completed packet |

## Verification
Two register stages lie between the input and the result: the beat-pairing register and the CRC state register. The checksum and done strobe for a packet are therefore due exactly two rising edges after the edge that takes its final beat, whether or not the pair was complete. When the bench drives a final beat, it records the expected value and the edge count at which that result must appear. A monitor that samples on the falling edge then requires `done_o` at that exact count and no other. On every other cycle it also checks that `crc_o` has not moved. Expected checksums come from a bit-serial model run over the same bytes, so back-to-back packets and gapped packets are checked with the same timing rule.

// File: rtl/crc64_pkg.sv
package crc64_pkg;
    localparam int BYTE_W = 8;
    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] PRESET = '1;
    localparam logic [CRC_W-1:0] XOR_OUT = '1;

    typedef logic [CRC_W-1:0] crc_t;

    // folds one byte, least significant bit first, into a reflected state
    function automatic crc_t crc_fold_byte(crc_t cur, logic [BYTE_W-1:0] b);
        crc_t t;
        t = cur ^ crc_t'(b);
        for (int i = 0; i < BYTE_W; i++) begin
            t = t[0] ? ((t >> 1) ^ POLY_REFL) : (t >> 1);
        end
        return t;
    endfunction
endpackage

// File: rtl/crc_pair_pack.sv
module crc_pair_pack #(
    parameter int LANES = 4,
    localparam int DW = LANES * crc64_pkg::BYTE_W,
    localparam int PW = 2 * DW,
    localparam int CW = $clog2(2 * LANES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [LANES-1:0] in_keep,
    input  logic          in_last,
    output logic          pk_en,
    output logic [PW-1:0] pk_data,
    output logic [CW-1:0] pk_cnt,
    output logic          pk_eop
);
    typedef struct packed {
        logic          have_low;
        logic [DW-1:0] low;
        logic          en;
        logic [PW-1:0] word;
        logic [CW-1:0] cnt;
        logic          eop;
    } pack_st_t;

    pack_st_t st_d, st_q;
    logic [CW-1:0] keep_cnt;

    always_comb begin
        keep_cnt = '0;
        for (int i = 0; i < LANES; i++) begin
            keep_cnt = keep_cnt + CW'(in_keep[i]);
        end

        st_d = st_q;
        st_d.en = 1'b0;
        st_d.eop = 1'b0;
        if (in_valid) begin
            if (!st_q.have_low) begin
                if (in_last) begin
                    // lone final beat: update right away, upper half empty
                    st_d.en = 1'b1;
                    st_d.word = {{DW{1'b0}}, in_data};
                    st_d.cnt = keep_cnt;
                    st_d.eop = 1'b1;
                end else begin
                    st_d.have_low = 1'b1;
                    st_d.low = in_data;
                end
            end else begin
                st_d.en = 1'b1;
                st_d.word = {in_data, st_q.low};
                st_d.cnt = CW'(LANES) + keep_cnt;
                st_d.eop = in_last;
                st_d.have_low = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pk_en = st_q.en;
    assign pk_data = st_q.word;
    assign pk_cnt = st_q.cnt;
    assign pk_eop = st_q.eop;
endmodule

// File: rtl/crc_update_bank.sv
module crc_update_bank #(
    parameter int NBYTES = 8,
    localparam int PW = NBYTES * crc64_pkg::BYTE_W,
    localparam int CW = $clog2(NBYTES + 1)
) (
    input  crc64_pkg::crc_t crc_in,
    input  logic [PW-1:0]   data,
    input  logic [CW-1:0]   cnt,
    output crc64_pkg::crc_t crc_out
);
    import crc64_pkg::*;

    logic [NBYTES:0][CRC_W-1:0] res;
    assign res[0] = crc_in;

    // one independent network per byte count, all evaluated in parallel
    for (genvar g = 1; g <= NBYTES; g++) begin : g_width
        crc_t net;
        always_comb begin
            net = crc_in;
            for (int k = 0; k < g; k++) begin
                net = crc_fold_byte(net, data[k*BYTE_W +: BYTE_W]);
            end
        end
        assign res[g] = net;
    end

    always_comb begin
        crc_out = crc_in;
        for (int g = 1; g <= NBYTES; g++) begin
            if (cnt == CW'(g)) crc_out = res[g];
        end
    end
endmodule

// File: rtl/crc64_pair_engine.sv
module crc64_pair_engine #(
    parameter int LANES = 4,
    localparam int DW = LANES * crc64_pkg::BYTE_W,
    localparam int PW = 2 * DW,
    localparam int NB = 2 * LANES,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic [LANES-1:0] in_keep,
    input  logic             in_last,
    output logic             done_o,
    output logic [31:0]      crc_o
);
    import crc64_pkg::*;

    typedef struct packed {
        crc_t crc;
        logic done;
        crc_t result;
    } eng_st_t;

    logic          pk_en;
    logic [PW-1:0] pk_data;
    logic [CW-1:0] pk_cnt;
    logic          pk_eop;
    crc_t          upd;
    eng_st_t       st_d, st_q;

    crc_pair_pack #(.LANES(LANES)) u_pack (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_data (in_data),
        .in_keep (in_keep),
        .in_last (in_last),
        .pk_en   (pk_en),
        .pk_data (pk_data),
        .pk_cnt  (pk_cnt),
        .pk_eop  (pk_eop)
    );

    crc_update_bank #(.NBYTES(NB)) u_bank (
        .crc_in (st_q.crc),
        .data   (pk_data),
        .cnt    (pk_cnt),
        .crc_out(upd)
    );

    always_comb begin
        st_d = st_q;
        st_d.done = 1'b0;
        if (pk_en) begin
            if (pk_eop) begin
                st_d.result = upd ^ XOR_OUT;
                st_d.done = 1'b1;
                st_d.crc = PRESET;
            end else begin
                st_d.crc = upd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.crc <= PRESET;
            st_q.done <= 1'b0;
            st_q.result <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign crc_o = st_q.result;
endmodule

// File: rtl/crc64_pair_chk.sv
module crc64_pair_chk #(
    parameter int LANES = 4,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          pk_en,
    input logic [CW-1:0] pk_cnt,
    input logic          pk_eop,
    input logic          done_o,
    input logic [31:0]   crc_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done_o && crc_o == 32'h0));

    // R7
    done_after_eop_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(pk_en && pk_eop));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(crc_o));

    // R6
    enable_from_beat_chk: assert property (@(posedge clk) disable iff (rst)
        pk_en |-> $past(in_valid));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        pk_en |-> (pk_cnt >= CW'(1) && pk_cnt <= CW'(2 * LANES)));

    // R5
    full_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (pk_en && !pk_eop) |-> (pk_cnt == CW'(2 * LANES)));
endmodule

bind crc64_pair_engine crc64_pair_chk #(.LANES(LANES), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .pk_en   (pk_en),
    .pk_cnt  (pk_cnt),
    .pk_eop  (pk_eop),
    .done_o  (done_o),
    .crc_o   (crc_o)
);

// File: tb/tb_crc64_pair_engine.sv
`timescale 1ns/1ps
module tb_crc64_pair_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [3:0]  in_keep = '0;
    logic        in_last = 1'b0;
    logic        done_o;
    logic [31:0] crc_o;

    always #2.5 clk = ~clk;

    crc64_pair_engine dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_keep(in_keep), .in_last(in_last), .done_o(done_o), .crc_o(crc_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0]  pb [0:127];
    logic [31:0] exp_crc [0:511];
    int          exp_at [0:511];
    string       exp_tag [0:511];
    int wr = 0;
    int rd = 0;
    logic        have_prev = 1'b0;
    logic [31:0] prev_crc = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ref_crc(int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < n; k++) begin
            c = c ^ {24'h0, pb[k]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic fill_bytes(int n, int seed);
        for (int k = 0; k < n; k++) pb[k] = 8'((seed * 37) + (k * 11) + n + (k * k));
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 32'hC3000000 | 32'(cyc);
        in_keep = 4'b0101;
        in_last = 1'b1;
    endtask

    // mode bit0: idle cycles inside the packet; bit1: junk in empty lanes
    task automatic send_pkt(int n, int mode, logic [31:0] expv, string tag);
        int nbeats = (n + 3) / 4;
        for (int j = 0; j < nbeats; j++) begin
            int rem = n - 4 * j;
            if (mode[0] && (j % 2 == 1)) idle_cycle();
            @(negedge clk);
            in_valid = 1'b1;
            in_last = (j == nbeats - 1);
            in_keep = (rem >= 4) ? 4'b1111 : 4'((1 << rem) - 1);
            for (int i = 0; i < 4; i++) begin
                if (i < rem) in_data[8*i +: 8] = pb[4*j + i];
                else         in_data[8*i +: 8] = mode[1] ? 8'(8'h5A + i + j) : 8'h00;
            end
            if (in_last) begin
                exp_crc[wr] = expv;
                exp_at[wr] = cyc + 2;
                exp_tag[wr] = tag;
                wr = wr + 1;
            end
        end
    endtask

    // result monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (rd < wr && cyc == exp_at[rd]) begin
                total = total + 1;
                if (!(done_o === 1'b1 && crc_o === exp_crc[rd])) begin
                    bad = bad + 1;
                    $display("FAIL %s: pkt %0d done=%0b crc=%08h expected done=1 crc=%08h",
                             exp_tag[rd], rd, done_o, crc_o, exp_crc[rd]);
                end
                prev_crc = exp_crc[rd];
                have_prev = 1'b1;
                rd = rd + 1;
            end else if (done_o !== 1'b0) begin
                total = total + 1;
                bad = bad + 1;
                $display("FAIL R7: done=%0b at cycle %0d expected 0", done_o, cyc);
            end else if (have_prev) begin
                total = total + 1;
                if (crc_o !== prev_crc) begin
                    bad = bad + 1;
                    $display("FAIL R7: held crc=%08h expected %08h", crc_o, prev_crc);
                end
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        bad = bad + 1;
        $display("FAIL R7: watchdog finished=0 expected 1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        total = total + 1;
        if (done_o !== 1'b0 || crc_o !== 32'h0) begin
            bad = bad + 1;
            $display("FAIL R1: in reset done=%0b crc=%08h expected 0 00000000", done_o, crc_o);
        end
        rst = 1'b0;
        @(negedge clk);
        total = total + 1;
        if (done_o !== 1'b0 || crc_o !== 32'h0) begin
            bad = bad + 1;
            $display("FAIL R1: after reset done=%0b crc=%08h expected 0 00000000", done_o, crc_o);
        end

        // R2 check value, R3 lane order
        for (int k = 0; k < 9; k++) pb[k] = 8'h31 + 8'(k);
        send_pkt(9, 0, 32'hCBF43926, "R2");
        idle_cycle();
        idle_cycle();

        // R5 every length, gapless, back to back (R8)
        for (int n = 1; n <= 70; n++) begin
            fill_bytes(n, n);
            send_pkt(n, 0, ref_crc(n), "R5");
        end
        idle_cycle();

        // R4 junk in empty lanes, R6 idle cycles with junk inside packets
        for (int n = 1; n <= 70; n++) begin
            fill_bytes(n, n + 100);
            send_pkt(n, 3, ref_crc(n), "R4/R6");
            if (n % 3 == 0) begin idle_cycle(); idle_cycle(); end
        end

        // R8 short packets with no idle between them
        for (int r = 0; r < 6; r++) begin
            int n = (r % 3) + 1;
            fill_bytes(n, r + 200);
            send_pkt(n, 2, ref_crc(n), "R8");
        end

        repeat (6) idle_cycle();
        total = total + 1;
        if (rd != wr) begin
            bad = bad + 1;
            $display("FAIL R7: results seen=%0d expected %0d", rd, wr);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule